// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block runs one four-beat read burst against synchronous DRAM each time a request is accepted. The burst uses the read command that closes the row by itself, so no separate precharge command is needed. A request carries a chip-select space, a row address and a column address. The sequencer opens the row with an activate command. After a programmable activate-to-read delay it issues the read command, with the auto-precharge address bit set. It then waits out the CAS latency and samples four consecutive 32-bit words from the data bus. Each word is presented to the requester with a one-cycle valid strobe.

There are two chip-select spaces. Each has its own 2-bit CAS latency setting, covering 1 to 4 cycles, and its own activate-to-read delay of 1 or 2 cycles. The settings are taken from configuration inputs when a request is accepted, so a burst in flight is not disturbed when they change. A latency of 4 serves systems with a latch on the data path; the sequencer only counts one more cycle. After the last beat come a data-end cycle and a precharge-wait cycle. A new request can only be accepted on the edge that ends the precharge-wait cycle, or later.

Top module: `sdram_burst_rd_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sd_cs_n_o` is all ones, `sd_ras_n_o`, `sd_cas_n_o` and `sd_rdwr_o` are 1, and `ack_o` and `rvalid_o` are 0.
- R2: A request (`req_i` high while the sequencer is idle) produces an activate in the next cycle. In that cycle `sd_ras_n_o`=0, `sd_cas_n_o`=1, `sd_addr_o`=`row_i`, `ack_o`=1, and only the chip select of the requested space is low (`space_i`=0 drives bit 0 low, `space_i`=1 drives bit 1 low).
- R3: The read command follows the activate by 1 cycle when that space's bit of `cfg_rcd_i` is 0, and by 2 cycles when it is 1. Space 0 uses bit 0 and space 1 uses bit 1.
- R4: In the read-command cycle `sd_cas_n_o`=0, `sd_ras_n_o`=1 and `sd_rdwr_o`=1, and the same chip select as the activate is low. `sd_addr_o` carries the column in bits [COL_W-1:0], has bit AP_BIT (10) set to 1, and has every other bit 0.
- R5: The CAS latency code of the requested space (`cfg_cl_i[1:0]` for space 0, `cfg_cl_i[3:2]` for space 1) maps 00/01/10/11 to 1/2/3/4 cycles. The first word is sampled from `sd_dq_i` in the cycle that lies that many cycles after the read-command cycle.
- R6: Four words are sampled in four consecutive cycles. Each appears on `rdata_o` with `rvalid_o`=1 in the cycle after it is sampled, and `rvalid_o` pulses exactly four times per burst.
- R7: The cycle after the last sampled word is a data-end cycle, and the one after that is a precharge-wait cycle. Both carry no command. If `req_i` is held high, the next activate comes in the cycle right after the precharge-wait cycle.
- R8: A request raised, or request and configuration inputs changed, while a burst is in progress is not acknowledged and has no effect on the current burst. The current burst keeps the row, column, space and timing captured at acceptance.
- R9: Any cycle that is neither activate nor read command has all chip selects high, `sd_ras_n_o`=`sd_cas_n_o`=1, `sd_rdwr_o`=1 and `sd_addr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Burst request |
| space_i | input | 1 | Chip-select space of the request |
| row_i | input | ADDR_W (13) | Row address for the activate |
| col_i | input | COL_W (10) | Column address for the read |
| cfg_cl_i | input | 4 | CAS latency codes, 2 bits per space |
| cfg_rcd_i | input | 2 | Activate-to-read delay bit per space |
| ack_o | output | 1 | Request accepted; high in the activate cycle |
| sd_cs_n_o | output | 2 | Active-low chip selects, one per space |
| sd_ras_n_o | output | 1 | Active-low row strobe |
| sd_cas_n_o | output | 1 | Active-low column strobe |
| sd_rdwr_o | output | 1 | Read/write direction, 1 = read |
| sd_addr_o | output | ADDR_W (13) | DRAM address bus |
| sd_dq_i | input | DATA_W (32) | DRAM read data |
| rdata_o | output | DATA_W (32) | Captured read word |
| rvalid_o | output | 1 | Read word valid strobe |

## Verification
Directed bursts sweep every latency code with both delay settings, in each space. The other space is always loaded with the opposite settings, so any mix-up of per-space fields shifts the command or sample cycles. The data bus carries a word that is different in every cycle of every burst, so a capture one cycle early or late gives a wrong value rather than a silent match. Seeded random bursts then mix isolated requests with back-to-back ones. In back-to-back bursts the request stays high and the address and configuration inputs change mid-burst, which separates correct capture-at-acceptance and the precharge-wait turnaround from early acceptance or live use of the inputs.

// File: rtl/sdrb_pkg.sv
`timescale 1ns/1ps
package sdrb_pkg;

    localparam int NUM_SPACES = 2;
    localparam int SPACE_W    = $clog2(NUM_SPACES);
    localparam int CL_CODE_W  = 2;
    localparam int CL_W       = 3;   // holds 1..4
    localparam int OFF_W      = 3;   // burst offset up to CL+3 = 7

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_RCDW,
        ST_BURST,
        ST_DEND,
        ST_PWAIT
    } seq_state_e;

    typedef struct packed {
        logic [SPACE_W-1:0] space;
        logic [CL_W-1:0]    cl;
        logic               rcd2;
    } timing_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic rdwr;
    } cmd_t;

    localparam cmd_t CMD_NOP  = '{ras_n: 1'b1, cas_n: 1'b1, rdwr: 1'b1};
    localparam cmd_t CMD_ACT  = '{ras_n: 1'b0, cas_n: 1'b1, rdwr: 1'b1};
    localparam cmd_t CMD_READ = '{ras_n: 1'b1, cas_n: 1'b0, rdwr: 1'b1};

    // Latency code 0..3 stands for 1..4 cycles.
    function automatic logic [CL_W-1:0] cl_cycles(input logic [CL_CODE_W-1:0] code);
        return {1'b0, code} + CL_W'(1);
    endfunction

endpackage

// File: rtl/sdrb_cfg_sel.sv
`timescale 1ns/1ps
module sdrb_cfg_sel
    import sdrb_pkg::*;
(
    input  logic [SPACE_W-1:0]              space_i,
    input  logic [NUM_SPACES*CL_CODE_W-1:0] cfg_cl_i,
    input  logic [NUM_SPACES-1:0]           cfg_rcd_i,
    output timing_t                         tim_o
);

    timing_t tab [NUM_SPACES];

    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_space
        assign tab[g] = '{space: SPACE_W'(g),
                          cl:    cl_cycles(cfg_cl_i[g*CL_CODE_W +: CL_CODE_W]),
                          rcd2:  cfg_rcd_i[g]};
    end

    assign tim_o = tab[space_i];

endmodule

// File: rtl/sdrb_seq_fsm.sv
`timescale 1ns/1ps
module sdrb_seq_fsm
    import sdrb_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  timing_t           tim_i,
    input  logic [ADDR_W-1:0] row_i,
    input  logic [COL_W-1:0]  col_i,
    output logic              issue_act_o,
    output logic              issue_rd_o,
    output logic              beat_en_o,
    output logic [SPACE_W-1:0] space_o,
    output logic [ADDR_W-1:0] row_o,
    output logic [COL_W-1:0]  col_o
);

    seq_state_e        st_q, st_d;
    logic [OFF_W-1:0]  off_q, off_d;
    timing_t           tim_q, tim_d;
    logic [ADDR_W-1:0] row_q, row_d;
    logic [COL_W-1:0]  col_q, col_d;
    logic [OFF_W:0]    last_off;

    assign last_off = {1'b0, tim_q.cl} + (OFF_W+1)'(3);

    always_comb begin
        st_d  = st_q;
        off_d = off_q;
        tim_d = tim_q;
        row_d = row_q;
        col_d = col_q;
        case (st_q)
            ST_IDLE, ST_PWAIT: begin
                if (req_i) begin
                    st_d  = ST_ACT;
                    tim_d = tim_i;
                    row_d = row_i;
                    col_d = col_i;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_ACT: begin
                st_d  = tim_q.rcd2 ? ST_RCDW : ST_BURST;
                off_d = '0;
            end
            ST_RCDW: begin
                st_d  = ST_BURST;
                off_d = '0;
            end
            ST_BURST: begin
                if ({1'b0, off_q} == last_off) st_d = ST_DEND;
                else                          off_d = off_q + OFF_W'(1);
            end
            ST_DEND: st_d = ST_PWAIT;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            off_q <= '0;
            tim_q <= '0;
            row_q <= '0;
            col_q <= '0;
        end else begin
            st_q  <= st_d;
            off_q <= off_d;
            tim_q <= tim_d;
            row_q <= row_d;
            col_q <= col_d;
        end
    end

    // Bus outputs are registered from the next state, so a command is on
    // the bus during the cycle in which st_q holds the matching state.
    assign issue_act_o = (st_d == ST_ACT);
    assign issue_rd_o  = (st_d == ST_BURST) && (st_q != ST_BURST);
    assign beat_en_o   = (st_q == ST_BURST) && (off_q >= OFF_W'(tim_q.cl));
    assign space_o     = tim_d.space;
    assign row_o       = row_d;
    assign col_o       = col_d;

endmodule

// File: rtl/sdrb_bus_drv.sv
`timescale 1ns/1ps
module sdrb_bus_drv
    import sdrb_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 10,
    parameter int AP_BIT = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  issue_act_i,
    input  logic                  issue_rd_i,
    input  logic [SPACE_W-1:0]    space_i,
    input  logic [ADDR_W-1:0]     row_i,
    input  logic [COL_W-1:0]      col_i,
    output logic                  ack_o,
    output logic [NUM_SPACES-1:0] cs_n_o,
    output cmd_t                  cmd_o,
    output logic [ADDR_W-1:0]     addr_o
);

    cmd_t                  cmd_d;
    logic [NUM_SPACES-1:0] cs_n_d;
    logic [ADDR_W-1:0]     addr_d;
    logic [ADDR_W-1:0]     addr_rd;

    always_comb begin
        addr_rd                = '0;
        addr_rd[COL_W-1:0]     = col_i;
        addr_rd[AP_BIT]        = 1'b1;   // auto-precharge on this read

        cmd_d  = CMD_NOP;
        cs_n_d = '1;
        addr_d = '0;
        if (issue_act_i) begin
            cmd_d           = CMD_ACT;
            cs_n_d[space_i] = 1'b0;
            addr_d          = row_i;
        end else if (issue_rd_i) begin
            cmd_d           = CMD_READ;
            cs_n_d[space_i] = 1'b0;
            addr_d          = addr_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o  <= 1'b0;
            cs_n_o <= '1;
            cmd_o  <= CMD_NOP;
            addr_o <= '0;
        end else begin
            ack_o  <= issue_act_i;
            cs_n_o <= cs_n_d;
            cmd_o  <= cmd_d;
            addr_o <= addr_d;
        end
    end

endmodule

// File: rtl/sdrb_capture.sv
`timescale 1ns/1ps
module sdrb_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_en_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= beat_en_i;
            if (beat_en_i) rdata_o <= dq_i;
        end
    end

endmodule

// File: rtl/sdram_burst_rd_seq.sv
`timescale 1ns/1ps
module sdram_burst_rd_seq
    import sdrb_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 10,
    parameter int AP_BIT = 10,
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            req_i,
    input  logic [SPACE_W-1:0]              space_i,
    input  logic [ADDR_W-1:0]               row_i,
    input  logic [COL_W-1:0]                col_i,
    input  logic [NUM_SPACES*CL_CODE_W-1:0] cfg_cl_i,
    input  logic [NUM_SPACES-1:0]           cfg_rcd_i,
    output logic                            ack_o,
    output logic [NUM_SPACES-1:0]           sd_cs_n_o,
    output logic                            sd_ras_n_o,
    output logic                            sd_cas_n_o,
    output logic                            sd_rdwr_o,
    output logic [ADDR_W-1:0]               sd_addr_o,
    input  logic [DATA_W-1:0]               sd_dq_i,
    output logic [DATA_W-1:0]               rdata_o,
    output logic                            rvalid_o
);

    timing_t            tim_sel;
    logic               issue_act, issue_rd, beat_en;
    logic [SPACE_W-1:0] cmd_space;
    logic [ADDR_W-1:0]  cmd_row;
    logic [COL_W-1:0]   cmd_col;
    cmd_t               cmd;

    sdrb_cfg_sel u_cfg (
        .space_i   (space_i),
        .cfg_cl_i  (cfg_cl_i),
        .cfg_rcd_i (cfg_rcd_i),
        .tim_o     (tim_sel)
    );

    sdrb_seq_fsm #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .tim_i       (tim_sel),
        .row_i       (row_i),
        .col_i       (col_i),
        .issue_act_o (issue_act),
        .issue_rd_o  (issue_rd),
        .beat_en_o   (beat_en),
        .space_o     (cmd_space),
        .row_o       (cmd_row),
        .col_o       (cmd_col)
    );

    sdrb_bus_drv #(.ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) u_drv (
        .clk         (clk),
        .rst         (rst),
        .issue_act_i (issue_act),
        .issue_rd_i  (issue_rd),
        .space_i     (cmd_space),
        .row_i       (cmd_row),
        .col_i       (cmd_col),
        .ack_o       (ack_o),
        .cs_n_o      (sd_cs_n_o),
        .cmd_o       (cmd),
        .addr_o      (sd_addr_o)
    );

    sdrb_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .beat_en_i (beat_en),
        .dq_i      (sd_dq_i),
        .rdata_o   (rdata_o),
        .rvalid_o  (rvalid_o)
    );

    assign sd_ras_n_o = cmd.ras_n;
    assign sd_cas_n_o = cmd.cas_n;
    assign sd_rdwr_o  = cmd.rdwr;

endmodule

// File: rtl/sdrb_checker.sv
`timescale 1ns/1ps
module sdrb_checker #(
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10,
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ack_o,
    input logic [NUM_CS-1:0] sd_cs_n_o,
    input logic              sd_ras_n_o,
    input logic              sd_cas_n_o,
    input logic              sd_rdwr_o,
    input logic [ADDR_W-1:0] sd_addr_o,
    input logic              rvalid_o
);

    logic [2:0] beat_cnt;
    logic       seen_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_cnt <= '0;
            seen_ack <= 1'b0;
        end else if (ack_o) begin
            beat_cnt <= '0;
            seen_ack <= 1'b1;
        end else if (rvalid_o) begin
            beat_cnt <= beat_cnt + 3'd1;
        end
    end

    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~sd_cs_n_o));

    assert_act_with_ack_R2: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (!sd_ras_n_o && sd_cas_n_o && $countones(~sd_cs_n_o) == 1));

    assert_rcd_window_R3: assert property (@(posedge clk) disable iff (rst)
        !sd_cas_n_o |-> (!$past(sd_ras_n_o) || !$past(sd_ras_n_o, 2)));

    assert_read_ap_bit_R4: assert property (@(posedge clk) disable iff (rst)
        !sd_cas_n_o |-> (sd_addr_o[AP_BIT] && sd_ras_n_o && sd_rdwr_o
                         && $countones(~sd_cs_n_o) == 1));

    assert_read_same_cs_R4: assert property (@(posedge clk) disable iff (rst)
        (!sd_cas_n_o && !$past(sd_ras_n_o)) |-> (sd_cs_n_o == $past(sd_cs_n_o)));

    assert_four_beats_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_o && seen_ack) |-> (beat_cnt == 3'd4));

    assert_beat_limit_R6: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |-> (beat_cnt < 3'd4));

    assert_no_act_in_data_R7: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |-> sd_ras_n_o);

    assert_idle_lines_R9: assert property (@(posedge clk) disable iff (rst)
        (sd_ras_n_o && sd_cas_n_o) |-> ((&sd_cs_n_o) && sd_rdwr_o && sd_addr_o == '0));

endmodule

bind sdram_burst_rd_seq sdrb_checker #(
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT),
    .NUM_CS (2)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack_o      (ack_o),
    .sd_cs_n_o  (sd_cs_n_o),
    .sd_ras_n_o (sd_ras_n_o),
    .sd_cas_n_o (sd_cas_n_o),
    .sd_rdwr_o  (sd_rdwr_o),
    .sd_addr_o  (sd_addr_o),
    .rvalid_o   (rvalid_o)
);

// File: tb/sdram_burst_rd_seq_tb.sv
`timescale 1ns/1ps
module sdram_burst_rd_seq_tb;

    localparam int ADDR_W = 13;
    localparam int COL_W  = 10;
    localparam int AP_BIT = 10;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_i = 1'b0;
    logic              space_i = 1'b0;
    logic [ADDR_W-1:0] row_i = '0;
    logic [COL_W-1:0]  col_i = '0;
    logic [3:0]        cfg_cl_i = '0;
    logic [1:0]        cfg_rcd_i = '0;
    logic              ack_o;
    logic [1:0]        sd_cs_n_o;
    logic              sd_ras_n_o, sd_cas_n_o, sd_rdwr_o;
    logic [ADDR_W-1:0] sd_addr_o;
    logic [DATA_W-1:0] sd_dq_i = '0;
    logic [DATA_W-1:0] rdata_o;
    logic              rvalid_o;

    int n_chk  = 0;
    int n_fail = 0;
    int bid    = 0;
    bit done   = 1'b0;

    // fields of the burst being run
    logic              cur_space;
    logic [ADDR_W-1:0] cur_row;
    logic [COL_W-1:0]  cur_col;
    logic [3:0]        cur_cl;
    logic [1:0]        cur_rcd;

    always #2.5 clk = ~clk;

    sdram_burst_rd_seq #(
        .ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .DATA_W(DATA_W)
    ) u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .space_i(space_i),
        .row_i(row_i), .col_i(col_i), .cfg_cl_i(cfg_cl_i), .cfg_rcd_i(cfg_rcd_i),
        .ack_o(ack_o), .sd_cs_n_o(sd_cs_n_o), .sd_ras_n_o(sd_ras_n_o),
        .sd_cas_n_o(sd_cas_n_o), .sd_rdwr_o(sd_rdwr_o), .sd_addr_o(sd_addr_o),
        .sd_dq_i(sd_dq_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(input int b, input int k);
        return {8'(b), 8'(k) ^ 8'h5A, 16'(b * 31 + k * 7 + 16'h1357)};
    endfunction

    function automatic int exp_cl(input logic sp, input logic [3:0] cl);
        return sp ? int'(cl[3:2]) + 1 : int'(cl[1:0]) + 1;
    endfunction

    function automatic int exp_rcd(input logic sp, input logic [1:0] rcd);
        return sp ? int'(rcd[1]) + 1 : int'(rcd[0]) + 1;
    endfunction

    task automatic apply_cur();
        space_i   = cur_space;
        row_i     = cur_row;
        col_i     = cur_col;
        cfg_cl_i  = cur_cl;
        cfg_rcd_i = cur_rcd;
    endtask

    task automatic rand_cur();
        cur_space = 1'($urandom);
        cur_row   = ADDR_W'($urandom);
        cur_col   = COL_W'($urandom);
        cur_cl    = 4'($urandom);
        cur_rcd   = 2'($urandom);
    endtask

    task automatic chk_idle(input string tag);
        chk(sd_cs_n_o == 2'b11, tag, 64'(sd_cs_n_o), 64'h3);
        chk(sd_ras_n_o && sd_cas_n_o && sd_rdwr_o, tag,
            64'({sd_ras_n_o, sd_cas_n_o, sd_rdwr_o}), 64'h7);
        chk(sd_addr_o == '0, tag, 64'(sd_addr_o), 64'h0);
        chk(!ack_o, tag, 64'(ack_o), 64'h0);
    endtask

    // Precondition: at a negedge, req_i high with cur_* applied, sequencer
    // idle or in its precharge-wait cycle. Ends at the precharge-wait negedge.
    task automatic run_burst(input bit chain);
        int cl, rcd, first_s, last;
        logic [1:0]        cs_exp;
        logic [ADDR_W-1:0] rd_addr;
        cl      = exp_cl(cur_space, cur_cl);
        rcd     = exp_rcd(cur_space, cur_rcd);
        first_s = rcd + cl;
        last    = rcd + cl + 5;
        cs_exp  = cur_space ? 2'b01 : 2'b10;
        rd_addr = '0;
        rd_addr[COL_W-1:0] = cur_col;
        rd_addr[AP_BIT]    = 1'b1;
        @(posedge clk); @(negedge clk);
        for (int k = 0; k <= last; k++) begin
            if (k == 0) begin
                chk(sd_cs_n_o == cs_exp, "R2 act cs", 64'(sd_cs_n_o), 64'(cs_exp));
                chk(!sd_ras_n_o && sd_cas_n_o, "R2 act cmd",
                    64'({sd_ras_n_o, sd_cas_n_o}), 64'h1);
                chk(sd_addr_o == cur_row, "R2 act row", 64'(sd_addr_o), 64'(cur_row));
                chk(ack_o, "R2 ack", 64'(ack_o), 64'h1);
            end else if (k == rcd) begin
                chk(!sd_cas_n_o && sd_ras_n_o, "R3 read cycle",
                    64'({sd_ras_n_o, sd_cas_n_o}), 64'h2);
                chk(sd_cs_n_o == cs_exp, "R4 read cs", 64'(sd_cs_n_o), 64'(cs_exp));
                chk(sd_rdwr_o, "R4 rdwr", 64'(sd_rdwr_o), 64'h1);
                chk(sd_addr_o == rd_addr, "R4 col+ap", 64'(sd_addr_o), 64'(rd_addr));
                chk(!ack_o, chain ? "R8 ack busy" : "R2 single ack", 64'(ack_o), 64'h0);
            end else if (k >= last - 1) begin
                chk_idle("R7 end cycles");
            end else begin
                chk_idle(chain ? "R8 busy idle" : "R9 idle");
            end
            if (k == first_s + 1) begin
                chk(rvalid_o && rdata_o == pat(bid, k - 1), "R5 first beat",
                    64'({rvalid_o, rdata_o}), 64'({1'b1, pat(bid, k - 1)}));
            end else if (k > first_s + 1 && k <= first_s + 4) begin
                chk(rvalid_o && rdata_o == pat(bid, k - 1), "R6 beat",
                    64'({rvalid_o, rdata_o}), 64'({1'b1, pat(bid, k - 1)}));
            end else begin
                chk(!rvalid_o, "R6 no extra beat", 64'(rvalid_o), 64'h0);
            end
            sd_dq_i = pat(bid, k);
            if (k == 0 && !chain) req_i = 1'b0;
            if (k == 1 && chain) begin
                logic              s_sp;
                logic [ADDR_W-1:0] s_row;
                logic [COL_W-1:0]  s_col;
                logic [3:0]        s_cl;
                logic [1:0]        s_rcd;
                s_sp = cur_space; s_row = cur_row; s_col = cur_col;
                s_cl = cur_cl;    s_rcd = cur_rcd;
                rand_cur();
                apply_cur();
                // keep this burst's expectations on the captured fields
                {cur_space, s_sp}  = {s_sp, cur_space};
                {cur_row, s_row}   = {s_row, cur_row};
                {cur_col, s_col}   = {s_col, cur_col};
                {cur_cl, s_cl}     = {s_cl, cur_cl};
                {cur_rcd, s_rcd}   = {s_rcd, cur_rcd};
            end
            if (k < last) begin
                @(posedge clk); @(negedge clk);
            end
        end
        bid++;
        if (chain) begin
            cur_space = space_i; cur_row = row_i; cur_col = col_i;
            cur_cl    = cfg_cl_i; cur_rcd = cfg_rcd_i;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_idle("R1 in reset");
        chk(!rvalid_o, "R1 in reset rvalid", 64'(rvalid_o), 64'h0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk_idle("R1 after reset");
        chk(!rvalid_o, "R1 after reset rvalid", 64'(rvalid_o), 64'h0);
        repeat (2) begin
            @(posedge clk); @(negedge clk);
            chk_idle("R9 no request");
        end

        // directed sweep: every latency code and delay in each space,
        // the other space set to the opposite values
        for (int sp = 0; sp < 2; sp++) begin
            for (int cl = 0; cl < 4; cl++) begin
                for (int rc = 0; rc < 2; rc++) begin
                    cur_space = 1'(sp);
                    cur_row   = ADDR_W'(13'h1A5 + cl * 97 + rc * 3 + sp * 1000);
                    cur_col   = COL_W'(10'h3FF - cl * 17 - rc);
                    if (sp == 0) begin
                        cur_cl  = {2'(~cl), 2'(cl)};
                        cur_rcd = {1'(~rc), 1'(rc)};
                    end else begin
                        cur_cl  = {2'(cl), 2'(~cl)};
                        cur_rcd = {1'(rc), 1'(~rc)};
                    end
                    apply_cur();
                    req_i = 1'b1;
                    run_burst(1'b0);
                    repeat (2) begin
                        @(posedge clk); @(negedge clk);
                        chk_idle("R9 between bursts");
                    end
                end
            end
        end

        // directed back-to-back at the longest timing: next activate
        // must follow the precharge-wait cycle directly (R7)
        cur_space = 1'b1; cur_row = 13'h1FFF; cur_col = 10'h155;
        cur_cl = 4'hF; cur_rcd = 2'b11;
        apply_cur();
        req_i = 1'b1;
        run_burst(1'b1);
        run_burst(1'b0);
        @(posedge clk); @(negedge clk);
        chk_idle("R9 after chain");

        // seeded random mix of isolated and chained bursts
        for (int i = 0; i < 40; i++) begin
            bit chain;
            if (!req_i) begin
                rand_cur();
                apply_cur();
                req_i = 1'b1;
            end
            chain = (i < 39) && ($urandom_range(0, 1) == 1);
            run_burst(chain);
            if (!chain) begin
                int gap;
                gap = $urandom_range(0, 2);
                for (int g = 0; g < gap; g++) begin
                    @(posedge clk); @(negedge clk);
                    chk_idle("R9 random gap");
                end
            end
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule